// File: doc/BRIEF.md
# Time-Diverse Lockstep Compare Unit

This block sits between a main processing core, a redundant shadow copy of that core, and the single system bus. The main core alone drives the bus: its request bundle (valid, address, write data, byte strobes) passes straight through to the bus outputs. The shadow core never reaches the bus. It receives the same bus-side inputs as the main core, but through a delay line, so it runs a fixed number of cycles behind. The main core's request bundle goes through a delay line of the same depth, so the comparator sees the two copies aligned to the same logical step. A transient fault therefore cannot hit both copies while they are in the same internal state.

Any compared bit that differs sets a sticky error flag. The flag holds until a clear input is pulsed. At the first error the comparator also captures which bits disagreed, so monitoring logic can read them. For a number of edges equal to the delay depth after reset, comparison is held off while the delay lines fill.

Top module: `lockstep_cmp`

## Requirements
- R1: The bus outputs `bus_vld`, `bus_addr`, `bus_wdata` and `bus_strb` equal the main core's `main_*` inputs in the same cycle. The shadow inputs have no path to them.
- R2: `shadow_in` equals the value `core_in` had exactly DEPTH rising edges earlier (default DEPTH = 2). Edges taken while `rst` is high load zero.
- R3: After a synchronous active-high reset, `err` is low, `err_bits` is all zero and `shadow_in` is zero.
- R4: For the first DEPTH rising edges after reset is released, no compare result can set `err`. A forced mismatch in that window leaves `err` low.
- R5: From the (DEPTH+1)-th edge after reset on, `err` is high after any edge at which the delayed main bundle and the shadow bundle differ in the valid bit, any address bit or any strobe bit.
- R6: Write data is compared only when the delayed main valid and the shadow valid are both 1. A write-data difference while either valid is 0 does not set `err`.
- R7: Once set, `err` stays high on every later edge at which `err_clr` is low, even if the two bundles agree again.
- R8: An edge at which `err_clr` is high and no compared mismatch is present clears both `err` and `err_bits` to zero.
- R9: An edge at which `err_clr` is high and a compared mismatch is present leaves `err` high. `err_bits` is reloaded with the new mismatch vector.
- R10: `err_bits` is loaded with the mismatch vector only at the edge that raises `err`, and it holds while `err` stays set. Its layout is: bit 0 valid, bits [STRB_W:1] strobes, the next ADDR_W bits address, and the top DATA_W bits write data. A 1 marks a disagreeing bit.
- R11: When the shadow core is an exact copy of the main core fed from `shadow_in`, `err` stays low over an arbitrary run of inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| core_in | input | IN_W | Bus-side inputs presented to the main core |
| main_vld | input | 1 | Main core request valid |
| main_addr | input | ADDR_W | Main core request address |
| main_wdata | input | DATA_W | Main core write data |
| main_strb | input | DATA_W/8 | Main core byte strobes |
| shd_vld | input | 1 | Shadow core request valid |
| shd_addr | input | ADDR_W | Shadow core request address |
| shd_wdata | input | DATA_W | Shadow core write data |
| shd_strb | input | DATA_W/8 | Shadow core byte strobes |
| shadow_in | output | IN_W | Delayed copy of `core_in` for the shadow core |
| bus_vld | output | 1 | Bus request valid (from main core) |
| bus_addr | output | ADDR_W | Bus request address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_strb | output | DATA_W/8 | Bus byte strobes |
| err_clr | input | 1 | Clear pulse for the sticky error |
| err | output | 1 | Sticky lockstep error flag |
| err_bits | output | 1+DATA_W/8+ADDR_W+DATA_W | Mismatch vector captured at the first error |

## Verification
The properties assume that both cores are held in reset together with this block. They also assume a core's output depends only on the inputs it has seen since reset, so that zero inputs give zero outputs and the two copies agree once the delay lines are full. The bench keeps `core_in` at zero during reset and uses the same small register-based core for both copies. Faults are injected only by XOR-ing fixed masks onto the shadow outputs. The bench predicts each flag and vector from the mask, the shadow copy's valid bit and the edge count since reset.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Fill state of the delay lines after reset.
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_LIVE = 1'b1
  } lsc_phase_t;

  // Counter width able to hold the value d.
  function automatic int unsigned lsc_cnt_w(input int unsigned d);
    return (d < 1) ? 1 : $clog2(d + 1);
  endfunction

  // Width of the compared request bundle.
  function automatic int unsigned lsc_vec_w(input int unsigned aw, input int unsigned dw);
    return 1 + (dw / 8) + aw + dw;
  endfunction

endpackage

// File: rtl/lsc_delay.sv
module lsc_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (DEPTH == 0) begin : g_thru
    assign q = d;
  end else begin : g_line
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      logic [W-1:0] r;
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= d;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= g_stg[i-1].r;
        end
      end
    end
    assign q = g_stg[DEPTH-1].r;
  end

endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int VEC_W  = 1 + STRB_W + ADDR_W + DATA_W
) (
  input  logic [VEC_W-1:0] ref_vec,
  input  logic [VEC_W-1:0] chk_vec,
  output logic [VEC_W-1:0] mis_vec,
  output logic             hit
);

  localparam int WD_LO = VEC_W - DATA_W;

  // Bitwise disagreement; write-data bits count only when both copies request.
  function automatic logic [VEC_W-1:0] diff_mask(input logic [VEC_W-1:0] a,
                                                 input logic [VEC_W-1:0] b);
    logic [VEC_W-1:0] dv;
    dv = a ^ b;
    if (!(a[0] && b[0])) dv[VEC_W-1:WD_LO] = '0;
    return dv;
  endfunction

  assign mis_vec = diff_mask(ref_vec, chk_vec);
  assign hit     = |mis_vec;

endmodule

// File: rtl/lsc_errflag.sv
module lsc_errflag
  import lsc_pkg::*;
#(
  parameter int VEC_W = 69,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] mis_vec,
  input  logic             hit,
  input  logic             clr,
  output logic             cmp_en,
  output logic             set_evt,
  output logic             err,
  output logic [VEC_W-1:0] err_bits
);

  localparam int CNT_W = lsc_cnt_w(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fill_cnt;
  lsc_phase_t       phase;

  assign phase   = (fill_cnt == CNT_MAX) ? PH_LIVE : PH_FILL;
  assign cmp_en  = (phase == PH_LIVE);
  assign set_evt = cmp_en && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
    end else if (phase == PH_FILL) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err      <= 1'b0;
      err_bits <= '0;
    end else if (set_evt) begin
      err <= 1'b1;
      if (!err || clr) err_bits <= mis_vec;
    end else if (clr) begin
      err      <= 1'b0;
      err_bits <= '0;
    end
  end

endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lsc_pkg::*;
#(
  parameter int IN_W   = 33,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int STRB_W = DATA_W / 8,
  localparam int VEC_W  = 1 + STRB_W + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   core_in,
  input  logic              main_vld,
  input  logic [ADDR_W-1:0] main_addr,
  input  logic [DATA_W-1:0] main_wdata,
  input  logic [STRB_W-1:0] main_strb,
  input  logic              shd_vld,
  input  logic [ADDR_W-1:0] shd_addr,
  input  logic [DATA_W-1:0] shd_wdata,
  input  logic [STRB_W-1:0] shd_strb,
  output logic [IN_W-1:0]   shadow_in,
  output logic              bus_vld,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [STRB_W-1:0] bus_strb,
  input  logic              err_clr,
  output logic              err,
  output logic [VEC_W-1:0]  err_bits
);

  // Bundle layout: {wdata, addr, strb, vld}, vld at bit 0.
  logic [VEC_W-1:0] main_vec;
  logic [VEC_W-1:0] main_dly;
  logic [VEC_W-1:0] shd_vec;
  logic [VEC_W-1:0] mis_vec;
  logic             cmp_hit;
  logic             cmp_en;
  logic             set_evt;

  assign bus_vld   = main_vld;
  assign bus_addr  = main_addr;
  assign bus_wdata = main_wdata;
  assign bus_strb  = main_strb;

  assign main_vec = {main_wdata, main_addr, main_strb, main_vld};
  assign shd_vec  = {shd_wdata, shd_addr, shd_strb, shd_vld};

  // One depth parameter feeds both lines, so the two can never diverge.
  lsc_delay #(.W(IN_W), .DEPTH(DEPTH)) u_in_dly (
    .clk (clk),
    .rst (rst),
    .d   (core_in),
    .q   (shadow_in)
  );

  lsc_delay #(.W(VEC_W), .DEPTH(DEPTH)) u_out_dly (
    .clk (clk),
    .rst (rst),
    .d   (main_vec),
    .q   (main_dly)
  );

  lsc_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .ref_vec (main_dly),
    .chk_vec (shd_vec),
    .mis_vec (mis_vec),
    .hit     (cmp_hit)
  );

  lsc_errflag #(.VEC_W(VEC_W), .DEPTH(DEPTH)) u_flag (
    .clk      (clk),
    .rst      (rst),
    .mis_vec  (mis_vec),
    .hit      (cmp_hit),
    .clr      (err_clr),
    .cmp_en   (cmp_en),
    .set_evt  (set_evt),
    .err      (err),
    .err_bits (err_bits)
  );

endmodule

// File: rtl/lockstep_cmp_chk.sv
module lockstep_cmp_chk #(
  parameter int IN_W  = 33,
  parameter int VEC_W = 69,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  core_in,
  input logic [IN_W-1:0]  shadow_in,
  input logic             err,
  input logic             err_clr,
  input logic [VEC_W-1:0] err_bits,
  input logic             cmp_hit,
  input logic             cmp_en
);

  localparam int CK_W = $clog2(DEPTH + 3);
  localparam logic [CK_W-1:0] CK_MAX = CK_W'(DEPTH + 1);
  localparam logic [CK_W-1:0] CK_DEP = CK_W'(DEPTH);

  logic [CK_W-1:0] ck_cnt;

  always_ff @(posedge clk) begin
    if (rst) ck_cnt <= '0;
    else if (ck_cnt != CK_MAX) ck_cnt <= ck_cnt + 1'b1;
  end

  if (DEPTH == 2) begin : g_d2
    // R2
    shadow_delay_chk: assert property (@(posedge clk) disable iff (rst)
      (ck_cnt >= CK_W'(2)) |-> (shadow_in == $past(core_in, 2)));
  end

  // R3
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!err && err_bits == '0 && shadow_in == '0));

  // R4
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ck_cnt < CK_DEP) |=> !err);

  // R5
  mismatch_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cmp_hit) |=> err);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);

  // R8
  clear_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !(cmp_en && cmp_hit)) |=> (!err && err_bits == '0));

  // R10
  bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> $stable(err_bits));

  // R10
  bits_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (err_bits != '0));

  // R10
  bits_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !err |-> (err_bits == '0));

endmodule

bind lockstep_cmp lockstep_cmp_chk #(
  .IN_W  (IN_W),
  .VEC_W (VEC_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .core_in   (core_in),
  .shadow_in (shadow_in),
  .err       (err),
  .err_clr   (err_clr),
  .err_bits  (err_bits),
  .cmp_hit   (cmp_hit),
  .cmp_en    (cmp_en)
);

// File: tb/test_lockstep_cmp.sv
module tb_core_model (
  input  logic        clk,
  input  logic        rst,
  input  logic [32:0] din,
  output logic        vld,
  output logic [31:0] addr,
  output logic [31:0] wdata,
  output logic [3:0]  strb
);
  // Zero inputs give zero outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0; addr <= '0; wdata <= '0; strb <= '0;
    end else begin
      vld   <= din[0];
      addr  <= {din[32:3], 2'b00};
      wdata <= {din[16:1], din[32:17]};
      strb  <= din[8:5];
    end
  end
endmodule

module test_lockstep_cmp;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 2;
  localparam int IN_W   = 33;
  localparam int VW     = 69;
  localparam int NVEC   = 18;
  localparam logic [31:0] F_ADDR  = 32'h0000_0100;
  localparam logic [31:0] F_WDATA = 32'h8000_0000;
  localparam logic [3:0]  F_STRB  = 4'b0010;

  // {core_in, fault select {strb,wdata,addr,vld}, clear}
  localparam logic [37:0] VECS [0:NVEC-1] = '{
    {32'h1111_2222, 1'b1, 4'b0000, 1'b0},
    {32'h3333_4444, 1'b0, 4'b0001, 1'b0},
    {32'h5555_6666, 1'b1, 4'b0000, 1'b0},
    {32'h7777_8888, 1'b1, 4'b0000, 1'b0},
    {32'h9999_AAAA, 1'b0, 4'b0100, 1'b0},
    {32'hBBBB_CCCC, 1'b0, 4'b0100, 1'b0},
    {32'hDDDD_EEEE, 1'b1, 4'b0010, 1'b0},
    {32'h0F0F_F0F0, 1'b1, 4'b0000, 1'b1},
    {32'h1234_5678, 1'b0, 4'b0000, 1'b0},
    {32'h2468_ACE0, 1'b1, 4'b1000, 1'b0},
    {32'h1357_9BDF, 1'b1, 4'b0000, 1'b0},
    {32'hFEDC_BA98, 1'b0, 4'b0010, 1'b1},
    {32'h0000_0000, 1'b0, 4'b0000, 1'b1},
    {32'hCAFE_F00D, 1'b1, 4'b0000, 1'b0},
    {32'hDEAD_BEEF, 1'b1, 4'b0001, 1'b0},
    {32'h0BAD_CAFE, 1'b0, 4'b0000, 1'b0},
    {32'h5A5A_A5A5, 1'b1, 4'b0000, 1'b1},
    {32'h6C6C_3939, 1'b1, 4'b0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0] core_in = '0;
  logic [3:0] fsel = '0;
  logic err_clr = 1'b0;

  logic m_vld, s_vld;
  logic [31:0] m_addr, m_wdata, s_addr, s_wdata;
  logic [3:0] m_strb, s_strb;
  logic [IN_W-1:0] shadow_in;
  logic bus_vld, err;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0] bus_strb;
  logic [VW-1:0] err_bits;

  int checks = 0;
  int fails = 0;
  int edge_cnt = 0;
  logic exp_err = 1'b0;
  logic [VW-1:0] exp_bits = '0;
  logic [IN_W-1:0] hist [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  tb_core_model u_main (.clk(clk), .rst(rst), .din(core_in),
    .vld(m_vld), .addr(m_addr), .wdata(m_wdata), .strb(m_strb));
  tb_core_model u_shadow (.clk(clk), .rst(rst), .din(shadow_in),
    .vld(s_vld), .addr(s_addr), .wdata(s_wdata), .strb(s_strb));

  lockstep_cmp i_lockstep_cmp (
    .clk(clk), .rst(rst), .core_in(core_in),
    .main_vld(m_vld), .main_addr(m_addr), .main_wdata(m_wdata), .main_strb(m_strb),
    .shd_vld(s_vld ^ fsel[0]),
    .shd_addr(s_addr ^ (fsel[1] ? F_ADDR : 32'h0)),
    .shd_wdata(s_wdata ^ (fsel[2] ? F_WDATA : 32'h0)),
    .shd_strb(s_strb ^ (fsel[3] ? F_STRB : 4'h0)),
    .shadow_in(shadow_in),
    .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
    .err_clr(err_clr), .err(err), .err_bits(err_bits));

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; core_in = '0; fsel = '0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    edge_cnt = 0; exp_err = 1'b0; exp_bits = '0;
    for (int i = 0; i < DEPTH; i++) hist[i] = '0;
    // R3: reset state visible at the ports
    check(err == 1'b0, "R3 err", VW'(err), '0);
    check(err_bits == '0, "R3 err_bits", err_bits, '0);
    check(shadow_in == '0, "R3 shadow_in", VW'(shadow_in), '0);
  endtask

  // Called at a falling edge; applies one cycle and checks after the next rising edge.
  task automatic step(input logic [IN_W-1:0] din, input logic [3:0] fs,
                      input logic clr, input string tag);
    logic [VW-1:0] mv;
    logic live;
    core_in = din; fsel = fs; err_clr = clr;
    #1;
    for (int i = DEPTH - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = din;
    edge_cnt++;
    live = (edge_cnt > DEPTH);
    mv = '0;
    mv[0] = fs[0];
    if (fs[3]) mv[4:1] = F_STRB;
    if (fs[1]) mv[36:5] = F_ADDR;
    if (fs[2] && s_vld && !fs[0]) mv[68:37] = F_WDATA;
    if (live && mv != '0) begin
      if (!exp_err || clr) exp_bits = mv;
      exp_err = 1'b1;
    end else if (clr) begin
      exp_err = 1'b0;
      exp_bits = '0;
    end
    @(posedge clk);
    @(negedge clk);
    check(err == exp_err, tag, VW'(err), VW'(exp_err));
    check(err_bits == exp_bits, {tag, " R10 vector"}, err_bits, exp_bits);
    check(shadow_in == hist[DEPTH-1], "R2 shadow_in", VW'(shadow_in), VW'(hist[DEPTH-1]));
    check({bus_vld, bus_addr, bus_wdata, bus_strb} == {m_vld, m_addr, m_wdata, m_strb},
          "R1 bus", VW'({bus_vld, bus_addr, bus_wdata, bus_strb}),
          VW'({m_vld, m_addr, m_wdata, m_strb}));
  endtask

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [IN_W-1:0] lf;
    do_reset();
    // Table: R4 warm-up fault, R6 both sides, R5, R7, R8, R9, R10
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = (v < 2) ? "R4" : (v == 4 || v == 5) ? "R6" : (v == 6 || v == 10) ? "R7" :
            (v == 11) ? "R9" : VECS[v][0] ? "R8" : "R5";
      step(VECS[v][37:5], VECS[v][4:1], VECS[v][0], tag);
    end
    // Reset in the middle of a run with err set.
    step({32'h1, 1'b1}, 4'b0001, 1'b0, "R5");
    do_reset();
    // R4: mismatch forced during the fill window is ignored.
    step({32'hAAAA_5555, 1'b1}, 4'b0011, 1'b0, "R4");
    step({32'h5555_AAAA, 1'b1}, 4'b1001, 1'b0, "R4");
    step({32'h0000_FFFF, 1'b1}, 4'b0010, 1'b0, "R5");
    step({32'h0, 1'b0}, 4'b0000, 1'b1, "R8");
    // R11: long agreeing run with varied inputs.
    lf = 33'h1_2345_6789;
    for (int n = 0; n < 200; n++) begin
      lf = {lf[31:0], lf[32] ^ lf[19]};
      step(lf, 4'b0000, 1'b0, "R11");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule